// File: doc/BRIEF.md
# Synchronous Framed Serial Receiver

This block takes a serial bit stream together with the clock that travels beside it. It samples the data on each rising edge of that clock and hunts through the stream for a programmed 8-bit sync pattern. Once the pattern appears, the following bits become bytes in a serial-to-parallel shift register, most significant bit first. After a programmed number of data bytes, the next 16 bits are taken as the frame check value.

Each received byte goes into an eight-entry buffer, where the processor reads it one byte at a time. The data bytes and the 16 check bits all pass through a CRC register. A frame is good when that register is zero after the last check bit. A 16-bit status word reports live buffer state and four sticky event flags. The processor clears a sticky flag by writing 1 to its bit. An interrupt line reports any sticky flag and has one global enable.

The block runs in the system clock domain. The serial clock and data are synchronised and edge-detected, so the serial clock must stay well below the system clock.

Top module: `usrx_top`

## Requirements
- R1: After reset, status reads 0x0000, irq is low and rd_valid is low.
- R2: A bit is taken on every rising edge of ser_clk. The receiver hunts only while rx_en is high. It accepts a sync match only when at least 8 bits have arrived since hunting began, and a match means the last 8 bits, first-received bit as MSB, equal sync_pat. With rx_en low, a whole frame on the line leaves status and buffer untouched.
- R3: After a sync match, exactly frame_len bytes (1..255) are assembled MSB first and pushed in order into the buffer, whether or not the CRC later passes. Data bytes equal to the sync pattern are stored as data.
- R4: The CRC uses polynomial 0x1021, preset 0xFFFF, MSB first, no final inversion, over the data bytes followed by the 16 received check bits. When the result is zero, status bit 3 (frame good) sets; otherwise status bit 4 (CRC error) sets. The receiver then returns to hunting.
- R5: The buffer holds 8 bytes. rd_data shows the oldest byte while rd_valid is high, and a one-cycle rd_en removes it.
- R6: A byte that arrives while the buffer holds 8 bytes is dropped and status bit 5 (overrun) sets. The stored bytes are unchanged, and a read in the same cycle does not make room for the arriving byte.
- R7: When 64 bits (parameter HUNT_LIMIT) have been hunted without a match, status bit 6 (sync error) sets and the count restarts. The 63rd bit does not set the bit.
- R8: Status layout: bit 0 buffer not empty, bit 1 buffer full, bit 2 frame in progress, bits 6..3 sticky flags, bits 11..8 buffer count, all other bits zero.
- R9: A cycle with clr_en high clears each sticky flag whose clr_bits bit is 1 and leaves the others set. An event in the same cycle wins over the clear.
- R10: irq is high exactly when irq_en is high and at least one sticky flag is set.
- R11: Dropping rx_en during a frame abandons it at once: the frame-in-progress bit goes low and the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Clock received with the serial data |
| ser_dat | input | 1 | Serial data |
| rx_en | input | 1 | Receiver enable |
| sync_pat | input | 8 | Sync pattern to hunt for |
| frame_len | input | 8 | Data bytes per frame (1..255) |
| rd_en | input | 1 | Remove the oldest buffered byte |
| rd_data | output | 8 | Oldest buffered byte |
| rd_valid | output | 1 | Buffer holds at least one byte |
| clr_en | input | 1 | Write strobe for flag clearing |
| clr_bits | input | 16 | Write-1-to-clear mask for status |
| irq_en | input | 1 | Global interrupt enable |
| status | output | 16 | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the buffer count never exceeds its depth;
- a dropped byte leaves the count unchanged;
- a byte strobe only leaves the data phase, and a frame verdict only leaves the check phase;
- disabling the receiver forces hunting;
- overrun and sync-error events always show in status on the next cycle, even against a simultaneous clear.

Other behaviours need the bench's frame sequences:
- correct byte order and values;
- the CRC verdict on clean and corrupted frames;
- the exact 63/64-bit boundary of the sync error;
- which bytes survive an overrun;
- recovery after an abort.

// File: rtl/usrx_pkg.sv
package usrx_pkg;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;

    // status bit positions
    localparam int unsigned SB_NEMPTY = 0;
    localparam int unsigned SB_FULL   = 1;
    localparam int unsigned SB_BUSY   = 2;
    localparam int unsigned SB_GOOD   = 3;
    localparam int unsigned SB_CRCE   = 4;
    localparam int unsigned SB_OVR    = 5;
    localparam int unsigned SB_SYNCE  = 6;
    localparam int unsigned SB_CNT    = 8;
    localparam logic [15:0] STICKY_MASK = 16'h0078;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_CHK  = 2'd2
    } rx_state_e;

    // one serial step of the CRC register, MSB first
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction
endpackage

// File: rtl/usrx_sampler.sv
module usrx_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    output logic bit_stb,
    output logic bit_val
);
    typedef struct packed {
        logic [1:0] ck;
        logic [1:0] dt;
        logic       ck_old;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d        = smp_q;
        smp_d.ck     = {smp_q.ck[0], ser_clk};
        smp_d.dt     = {smp_q.dt[0], ser_dat};
        smp_d.ck_old = smp_q.ck[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign bit_stb = smp_q.ck[1] & ~smp_q.ck_old;
    assign bit_val = smp_q.dt[1];

    // R2: one strobe per rising edge of the received clock, never two in a row
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> !bit_stb);
endmodule

// File: rtl/usrx_deframer.sv
module usrx_deframer
    import usrx_pkg::*;
#(
    parameter int unsigned HUNT_LIMIT = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] sync_pat,
    input  logic [7:0] frame_len,
    input  logic       bit_stb,
    input  logic       bit_val,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       frm_done,
    output logic       frm_ok,
    output logic       sync_err,
    output logic       in_frame
);
    localparam int unsigned HW = $clog2(HUNT_LIMIT);

    typedef struct packed {
        rx_state_e   state;
        logic [7:0]  sh;
        logic [3:0]  bitc;
        logic [7:0]  bytec;
        logic [3:0]  fill;
        logic [HW-1:0] hunt;
        logic [15:0] crc;
        logic        byte_stb;
        logic [7:0]  byte_val;
        logic        done;
        logic        ok;
        logic        serr;
    } dfr_t;

    dfr_t q, d;
    logic [7:0]  sh_n;
    logic [15:0] crc_n;

    always_comb begin
        d          = q;
        d.byte_stb = 1'b0;
        d.done     = 1'b0;
        d.serr     = 1'b0;
        sh_n       = {q.sh[6:0], bit_val};
        crc_n      = crc_step(q.crc, bit_val);
        if (!en) begin
            d.state = ST_HUNT;
            d.fill  = '0;
            d.hunt  = '0;
        end else if (bit_stb) begin
            d.sh = sh_n;
            unique case (q.state)
                ST_HUNT: begin
                    if (q.fill != 4'd8) d.fill = q.fill + 4'd1;
                    if (q.fill >= 4'd7 && sh_n == sync_pat) begin
                        d.state = ST_DATA;
                        d.bitc  = '0;
                        d.bytec = '0;
                        d.crc   = CRC_INIT;
                        d.hunt  = '0;
                    end else if (q.hunt == HW'(HUNT_LIMIT - 1)) begin
                        d.serr = 1'b1;
                        d.hunt = '0;
                    end else begin
                        d.hunt = q.hunt + 1'b1;
                    end
                end
                ST_DATA: begin
                    d.crc  = crc_n;
                    d.bitc = q.bitc + 4'd1;
                    if (q.bitc == 4'd7) begin
                        d.bitc     = '0;
                        d.byte_stb = 1'b1;
                        d.byte_val = sh_n;
                        d.bytec    = q.bytec + 8'd1;
                        if (q.bytec == frame_len - 8'd1) d.state = ST_CHK;
                    end
                end
                ST_CHK: begin
                    d.crc  = crc_n;
                    d.bitc = q.bitc + 4'd1;
                    if (q.bitc == 4'd15) begin
                        d.done  = 1'b1;
                        d.ok    = (crc_n == 16'h0000);
                        d.state = ST_HUNT;
                        d.fill  = '0;
                        d.hunt  = '0;
                    end
                end
                default: d.state = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_stb = q.byte_stb;
    assign byte_val = q.byte_val;
    assign frm_done = q.done;
    assign frm_ok   = q.ok;
    assign sync_err = q.serr;
    assign in_frame = (q.state != ST_HUNT);

    // R3: bytes are only delivered out of the data phase
    a_r3_byte_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        q.byte_stb |-> $past(q.state) == ST_DATA);
    // R4: a frame verdict only follows the check-value phase
    a_r4_done_from_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.state) == ST_CHK);
    // R11: a disabled receiver is back to hunting on the next cycle
    a_r11_abort_hunts: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> q.state == ST_HUNT);
endmodule

// File: rtl/usrx_fifo.sv
module usrx_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [WIDTH-1:0]         wdata,
    input  logic                     pop,
    output logic [WIDTH-1:0]         rdata,
    output logic                     empty,
    output logic                     full,
    output logic [$clog2(DEPTH):0]   count,
    output logic                     ovr
);
    localparam int unsigned AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [AW:0]                 cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != (AW+1)'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        d.cnt = q.cnt + (do_push ? 1'b1 : 1'b0) - (do_pop ? 1'b1 : 1'b0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign full  = (q.cnt == (AW+1)'(DEPTH));
    assign count = q.cnt;
    assign ovr   = push && full;

    // R5: occupancy never exceeds the depth
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= (AW+1)'(DEPTH));
    // R6: a dropped byte without a read leaves occupancy unchanged
    a_r6_drop_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !pop) |=> q.cnt == $past(q.cnt));
endmodule

// File: rtl/usrx_top.sv
module usrx_top
    import usrx_pkg::*;
#(
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned HUNT_LIMIT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_dat,
    input  logic        rx_en,
    input  logic [7:0]  sync_pat,
    input  logic [7:0]  frame_len,
    input  logic        rd_en,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic        clr_en,
    input  logic [15:0] clr_bits,
    input  logic        irq_en,
    output logic [15:0] status,
    output logic        irq
);
    localparam int unsigned CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic [15:0] flags;
    } top_t;

    top_t q, d;

    logic       bit_stb, bit_val;
    logic       byte_stb, frm_done, frm_ok, sync_err, in_frame;
    logic [7:0] byte_val;
    logic       f_empty, f_full, ovr_pls;
    logic [CW-1:0] f_cnt;
    logic [15:0] set_v, clr_v;

    usrx_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .bit_stb(bit_stb), .bit_val(bit_val)
    );

    usrx_deframer #(.HUNT_LIMIT(HUNT_LIMIT)) u_dfr (
        .clk(clk), .rst_n(rst_n), .en(rx_en), .sync_pat(sync_pat),
        .frame_len(frame_len), .bit_stb(bit_stb), .bit_val(bit_val),
        .byte_stb(byte_stb), .byte_val(byte_val), .frm_done(frm_done),
        .frm_ok(frm_ok), .sync_err(sync_err), .in_frame(in_frame)
    );

    usrx_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_buf (
        .clk(clk), .rst_n(rst_n), .push(byte_stb), .wdata(byte_val),
        .pop(rd_en), .rdata(rd_data), .empty(f_empty), .full(f_full),
        .count(f_cnt), .ovr(ovr_pls)
    );

    always_comb begin
        set_v           = '0;
        set_v[SB_GOOD]  = frm_done & frm_ok;
        set_v[SB_CRCE]  = frm_done & ~frm_ok;
        set_v[SB_OVR]   = ovr_pls;
        set_v[SB_SYNCE] = sync_err;
        clr_v           = clr_en ? clr_bits : 16'h0000;
        d.flags         = ((q.flags & ~clr_v) | set_v) & STICKY_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        status               = q.flags;
        status[SB_NEMPTY]    = ~f_empty;
        status[SB_FULL]      = f_full;
        status[SB_BUSY]      = in_frame;
        status[SB_CNT +: CW] = f_cnt;
    end

    assign rd_valid = ~f_empty;
    assign irq      = irq_en & (|q.flags);

    // R6, R9: an overrun shows in status even against a simultaneous clear
    a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pls |=> status[SB_OVR]);
    // R7, R9: a sync error shows in status on the next cycle
    a_r7_serr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> status[SB_SYNCE]);
    // R8: the unused status bits stay zero
    a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[15:12] == 4'h0 && !status[7]);
endmodule

// File: tb/usrx_top_test.sv
module usrx_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        rx_en = 1'b0;
    logic [7:0]  sync_pat = 8'h7E;
    logic [7:0]  frame_len = 8'd1;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        clr_en = 1'b0;
    logic [15:0] clr_bits = 16'h0000;
    logic        irq_en = 1'b0;
    logic [15:0] status;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usrx_top uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .rx_en(rx_en), .sync_pat(sync_pat), .frame_len(frame_len),
        .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .clr_en(clr_en), .clr_bits(clr_bits), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    // {len[2:0], corrupt, exp_good, exp_crcerr, bytes[31:0]}, first byte in [31:24]
    localparam logic [37:0] VECS [0:3] = '{
        {3'd3, 1'b0, 1'b1, 1'b0, 32'hA1B2C300},
        {3'd4, 1'b1, 1'b0, 1'b1, 32'h10203040},
        {3'd1, 1'b0, 1'b1, 1'b0, 32'h7E000000},
        {3'd4, 1'b0, 1'b1, 1'b0, 32'h00FF55AA}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [31:0] bytes, input int len);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < len; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic inb;
                inb = bytes[31 - 8*i - (7 - b)];
                if (c[15] ^ inb) c = {c[14:0], 1'b0} ^ 16'h1021;
                else             c = {c[14:0], 1'b0};
            end
        end
        return c;
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_dat = b;
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_frame(input logic [31:0] bytes, input int len, input logic bad);
        logic [15:0] c;
        c = ref_crc(bytes, len);
        if (bad) c[0] = ~c[0];
        frame_len = 8'(len);
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        send_byte(sync_pat);
        for (int i = 0; i < len; i++) send_byte(bytes[31 - 8*i -: 8]);
        send_byte(c[15:8]);
        send_byte(c[7:0]);
        repeat (6) @(negedge clk);
    endtask

    task automatic pop_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        chk(tag, {31'd0, rd_valid}, 32'd1);
        chk(tag, {24'd0, rd_data}, {24'd0, exp});
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic clear(input logic [15:0] m);
        @(negedge clk);
        clr_en = 1'b1;
        clr_bits = m;
        @(negedge clk);
        clr_en = 1'b0;
        clr_bits = 16'h0000;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", {16'd0, status}, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        chk("R1 rd_valid", {31'd0, rd_valid}, 32'h0);

        // R2: with rx_en low a whole frame is ignored
        send_frame(32'hDEADBEEF, 4, 1'b0);
        chk("R2 disabled ignores frame", {16'd0, status}, 32'h0);

        rx_en = 1'b1;
        irq_en = 1'b1;

        // R3 R4 R5: table of frames
        for (int v = 0; v < 4; v++) begin
            logic [37:0] e;
            int len;
            e = VECS[v];
            len = int'(e[37:35]);
            send_frame(e[31:0], len, e[34]);
            chk("R4 good flag", {31'd0, status[3]}, {31'd0, e[33]});
            chk("R4 crc error flag", {31'd0, status[4]}, {31'd0, e[32]});
            chk("R3 byte count", {28'd0, status[11:8]}, 32'(len));
            chk("R10 irq on flag", {31'd0, irq}, 32'd1);
            if (v == 0) chk("R8 full status word", {16'd0, status}, 32'h0309);
            for (int i = 0; i < len; i++) pop_chk("R3 R5 byte order", e[31 - 8*i -: 8]);
            @(negedge clk);
            chk("R5 empty after reads", {31'd0, rd_valid}, 32'd0);
            clear(16'hFFFF);
            chk("R9 all cleared", {16'd0, status}, 32'h0);
        end

        // R6: overrun with three four-byte frames and no reads
        send_frame(32'h01020304, 4, 1'b0);
        send_frame(32'h05060708, 4, 1'b0);
        chk("R6 no overrun at exactly full", {31'd0, status[5]}, 32'd0);
        send_frame(32'h090A0B0C, 4, 1'b0);
        chk("R6 overrun status", {16'd0, status}, 32'h082B);
        // R9: clear only the good flag, overrun stays
        clear(16'h0008);
        chk("R9 selective clear", {28'd0, status[6:3]}, 32'h4);
        for (int i = 0; i < 8; i++) pop_chk("R6 surviving bytes", 8'(i + 1));
        clear(16'hFFFF);

        // R7: 63 idle bits do not flag, the 64th does
        for (int i = 0; i < 63; i++) send_bit(1'b0);
        repeat (6) @(negedge clk);
        chk("R7 no sync error at 63", {31'd0, status[6]}, 32'd0);
        chk("R10 irq low without flag", {31'd0, irq}, 32'd0);
        send_bit(1'b0);
        repeat (6) @(negedge clk);
        chk("R7 sync error at 64", {31'd0, status[6]}, 32'd1);
        chk("R10 irq with flag", {31'd0, irq}, 32'd1);
        irq_en = 1'b0;
        @(negedge clk);
        chk("R10 global mask", {31'd0, irq}, 32'd0);
        irq_en = 1'b1;
        clear(16'h0040);
        chk("R9 sync flag cleared", {16'd0, status}, 32'h0);

        // R11: abort mid-frame, then a clean frame
        frame_len = 8'd2;
        for (int i = 0; i < 8; i++) send_bit(1'b0);
        send_byte(8'h7E);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        repeat (6) @(negedge clk);
        chk("R11 frame in progress", {31'd0, status[2]}, 32'd1);
        rx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 abort clears busy", {31'd0, status[2]}, 32'd0);
        rx_en = 1'b1;
        send_frame(32'hC35A0000, 2, 1'b0);
        chk("R11 recovery status", {16'd0, status}, 32'h0209);
        pop_chk("R11 byte 0", 8'hC3);
        pop_chk("R11 byte 1", 8'h5A);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule